// File: doc/BRIEF.md
# SPI Slave Message Buffer

This block is an SPI slave (clock idle low, data captured on the rising edge, changed on the falling edge, one active-low select) that trades length-prefixed messages between an external master and a local byte store. The master always drives the clock. Every transaction opens with a two-byte length header. When the length is nonzero, that many payload bytes follow and are written into the store. Once the header and payload are complete, the slave streams bytes from the store, starting at index 0, on every later byte slot of the same selection.

Each time select falls, a status byte is loaded into the transmit path. The master's first byte slot therefore returns the slave state at once. A busy slave can keep the master waiting, because the master simply re-selects and polls until it sees "data coming". Local logic writes an outgoing message into the store and posts its length. This raises an attention output, and the master answers it with a zero-length header to read the message. Received messages are signalled to local logic by a one-cycle strobe that carries the header length.

The SPI inputs pass through two-flop synchronisers. SCLK must therefore be slow enough that each half period spans several system clocks.

Top module: `spi_msg_slave`

## Requirements
- R1: After reset, `spi_miso`, `attn` and `msg_ready` are 0, and the transmit byte holds 0x00.
- R2: Bits move most significant bit first on both `spi_mosi` and `spi_miso`.
- R3: Each select fall loads a status byte for the first slot. The value is 0xA5 when a posted message is pending, otherwise 0x01 when `loc_busy` is high, otherwise 0x00. Bit 7 is ORed in when the overflow flag is set, and the flag clears once it has been loaded.
- R4: The first two received bytes form the length, upper byte first. Payload bytes are stored at indices 0, 1, 2, ... in order. After the last one, `msg_ready` pulses for one cycle and `msg_len` shows the header length.
- R5: After the header (zero length) or after the last payload byte, the following slots return store bytes from index 0 upward. For a write, the count is the header length capped at DEPTH. When a message is pending, the count is the posted length.
- R6: A slot with no newly loaded byte repeats the last loaded byte. This covers the header and payload slots, which repeat the status, and the slots after the stream runs out.
- R7: A header length above DEPTH (32) sets the overflow flag. Only the first DEPTH payload bytes are stored and the rest are discarded.
- R8: A `loc_post` pulse raises `attn` on the next cycle and marks the message pending. Entering the stream phase while a message is pending clears both.
- R9: Select going high at any point returns framing to the header wait, so the next selection starts with a fresh header and no strobe comes from the aborted one.
- R10: The local port writes the store synchronously and reads it combinationally at `loc_addr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low reset |
| spi_sclk | input | 1 | SPI clock from master |
| spi_cs_n | input | 1 | Active-low select |
| spi_mosi | input | 1 | Master-to-slave data |
| spi_miso | output | 1 | Slave-to-master data, 0 when deselected |
| attn | output | 1 | Requests the master to start a transfer |
| loc_we | input | 1 | Local store write enable |
| loc_addr | input | AW | Local store address |
| loc_wdata | input | 8 | Local write data |
| loc_rdata | output | 8 | Local read data |
| loc_post | input | 1 | Posts an outgoing message |
| loc_post_len | input | AW+1 | Length of the posted message |
| loc_busy | input | 1 | Selects busy status when nothing is pending |
| msg_ready | output | 1 | One-cycle strobe when a received message is complete |
| msg_len | output | LENW | Header length of the last completed message |

## Verification
Because of the synchronisers, a select fall or SCLK edge takes effect about three system clocks later. The bench therefore holds each SCLK half period for eight clocks and samples MISO just before the rising edge, after the value loaded on the previous falling edge has settled. The strobe and `attn` are due within a few clocks of the event. The bench counts strobes on falling clock edges and checks the count, `attn` and `msg_len` only after the whole transaction. Store contents are read through the local port between transactions, after one settling step.

// File: rtl/spi_msg_slave.sv
module spi_msg_slave #(
  parameter int DEPTH = 32,
  parameter int LENW  = 16,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            spi_sclk,
  input  logic            spi_cs_n,
  input  logic            spi_mosi,
  output logic            spi_miso,
  output logic            attn,
  input  logic            loc_we,
  input  logic [AW-1:0]   loc_addr,
  input  logic [7:0]      loc_wdata,
  output logic [7:0]      loc_rdata,
  input  logic            loc_post,
  input  logic [AW:0]     loc_post_len,
  input  logic            loc_busy,
  output logic            msg_ready,
  output logic [LENW-1:0] msg_len
);
  localparam logic [1:0] HDR_HI = 2'd0, HDR_LO = 2'd1, PAYLD = 2'd2, STRM = 2'd3;
  localparam logic [LENW-1:0] DEPTH_L = LENW'(DEPTH);
  localparam logic [AW:0]     DEPTH_A = (AW+1)'(DEPTH);

  logic [2:0] sck_s, cs_s;
  logic [1:0] mosi_s;
  logic [2:0] bitcnt;
  logic [6:0] rx_sh;
  logic [7:0] tx_sh, tx_hold, len_hi;
  logic [1:0] st;
  logic [LENW-1:0] hdr_len, wcnt;
  logic [AW:0] idx, slen, post_len;
  logic ovf, pending;
  logic [7:0] mem [DEPTH];

  wire cs_act   = !cs_s[1];
  wire cs_fall  = cs_s[2] & !cs_s[1];
  wire sck_rise = cs_act & !sck_s[2] & sck_s[1];
  wire sck_fall = cs_act & sck_s[2] & !sck_s[1];
  wire [7:0] byte_in = {rx_sh, mosi_s[1]};
  wire byte_done = sck_rise && bitcnt == 3'd7;
  wire [LENW-1:0] hdr_now = {len_hi, byte_in};

  function automatic logic [AW:0] cap_len(input logic [LENW-1:0] l);
    return (l > DEPTH_L) ? DEPTH_A : l[AW:0];
  endfunction

  wire [7:0] status = (pending ? 8'hA5 : loc_busy ? 8'h01 : 8'h00) | {ovf, 7'b0};
  wire spi_we = byte_done && st == PAYLD && wcnt < DEPTH_L;
  wire go_stream = byte_done && ((st == HDR_LO && hdr_now == '0) ||
                                 (st == PAYLD && (wcnt + 1'b1) == hdr_len));
  wire [AW:0] new_slen = pending ? post_len : cap_len(st == HDR_LO ? hdr_now : hdr_len);
  wire [7:0] first_byte = (st == PAYLD && wcnt == '0) ? byte_in : mem[0];

  assign spi_miso  = cs_act & tx_sh[7];
  assign loc_rdata = mem[loc_addr];

  always_ff @(posedge clk) begin
    if (spi_we) mem[wcnt[AW-1:0]] <= byte_in;
    else if (loc_we) mem[loc_addr] <= loc_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_s <= '0; cs_s <= '1; mosi_s <= '0;
      bitcnt <= '0; rx_sh <= '0; tx_sh <= '0; tx_hold <= '0; len_hi <= '0;
      st <= HDR_HI; hdr_len <= '0; wcnt <= '0; idx <= '0; slen <= '0;
      post_len <= '0; ovf <= 1'b0; pending <= 1'b0; attn <= 1'b0;
      msg_ready <= 1'b0; msg_len <= '0;
    end else begin
      sck_s  <= {sck_s[1:0], spi_sclk};
      cs_s   <= {cs_s[1:0], spi_cs_n};
      mosi_s <= {mosi_s[0], spi_mosi};
      msg_ready <= 1'b0;
      if (!cs_act) begin
        st <= HDR_HI;
        bitcnt <= '0;
      end else if (cs_fall) begin
        tx_sh <= status;
        tx_hold <= status;
        ovf <= 1'b0;
        bitcnt <= '0;
        st <= HDR_HI;
      end else begin
        if (sck_rise) begin
          rx_sh <= byte_in[6:0];
          bitcnt <= bitcnt + 1'b1;
        end
        if (sck_fall) tx_sh <= (bitcnt == 3'd0) ? tx_hold : {tx_sh[6:0], 1'b0};
        if (byte_done) begin
          case (st)
            HDR_HI: begin
              len_hi <= byte_in;
              st <= HDR_LO;
            end
            HDR_LO: begin
              hdr_len <= hdr_now;
              wcnt <= '0;
              if (hdr_now > DEPTH_L) ovf <= 1'b1;
              st <= PAYLD;
            end
            PAYLD: begin
              wcnt <= wcnt + 1'b1;
              if ((wcnt + 1'b1) == hdr_len) begin
                msg_ready <= 1'b1;
                msg_len <= hdr_len;
              end
            end
            default: begin
              if (idx < slen) begin
                tx_hold <= mem[idx[AW-1:0]];
                idx <= idx + 1'b1;
              end
            end
          endcase
        end
        if (go_stream) begin
          st <= STRM;
          slen <= new_slen;
          if (new_slen != '0) begin
            tx_hold <= first_byte;
            idx <= (AW+1)'(1);
          end else begin
            idx <= '0;
          end
          if (pending) begin
            pending <= 1'b0;
            attn <= 1'b0;
          end
        end
      end
      if (loc_post) begin
        pending <= 1'b1;
        attn <= 1'b1;
        post_len <= loc_post_len;
      end
    end
  end
endmodule

// File: rtl/spi_msg_slave_chk.sv
module spi_msg_slave_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_act,
  input logic [1:0] st,
  input logic       loc_post,
  input logic       attn,
  input logic       msg_ready
);
  a_r4_ready_single: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |=> !msg_ready);
  a_r4_ready_from_payload: assert property (@(posedge clk) disable iff (!rst_n)
    msg_ready |-> $past(st) == 2'd2);
  a_r8_attn_on_post: assert property (@(posedge clk) disable iff (!rst_n)
    loc_post |=> attn);
  a_r8_attn_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(attn) |-> $past(loc_post));
  a_r9_idle_header: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_act |=> st == 2'd0);
endmodule

bind spi_msg_slave spi_msg_slave_chk i_chk (
  .clk(clk), .rst_n(rst_n), .cs_act(cs_act), .st(st),
  .loc_post(loc_post), .attn(attn), .msg_ready(msg_ready)
);

// File: tb/test_spi_msg_slave.sv
module test_spi_msg_slave;
  localparam int CLK_PERIOD = 10;
  localparam int HALF = 8;
  localparam int AW = 5;

  logic clk = 0, rst_n = 0;
  logic sclk = 0, cs_n = 1, mosi = 0;
  logic miso, attn, loc_we = 0, loc_post = 0, loc_busy = 0, msg_ready;
  logic [AW-1:0] loc_addr = '0;
  logic [7:0] loc_wdata = '0, loc_rdata;
  logic [AW:0] loc_post_len = '0;
  logic [15:0] msg_len;
  int errors = 0, checks = 0, rdy_cnt = 0;
  bit done = 0;
  logic [7:0] r;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_msg_slave i_spi_msg_slave (
    .clk(clk), .rst_n(rst_n), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_mosi(mosi),
    .spi_miso(miso), .attn(attn), .loc_we(loc_we), .loc_addr(loc_addr),
    .loc_wdata(loc_wdata), .loc_rdata(loc_rdata), .loc_post(loc_post),
    .loc_post_len(loc_post_len), .loc_busy(loc_busy), .msg_ready(msg_ready),
    .msg_len(msg_len)
  );

  always @(negedge clk) if (rst_n && msg_ready) rdy_cnt++;

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic wclk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic xfer(input logic [7:0] d, output logic [7:0] q);
    for (int i = 7; i >= 0; i--) begin
      mosi = d[i];
      wclk(HALF);
      q[i] = miso;
      sclk = 1;
      wclk(HALF);
      sclk = 0;
    end
  endtask

  task automatic sel;
    cs_n = 0;
    wclk(HALF);
  endtask

  task automatic desel;
    wclk(HALF);
    cs_n = 1;
    wclk(HALF);
  endtask

  task automatic lw(input logic [AW-1:0] a, input logic [7:0] d);
    @(negedge clk);
    loc_we = 1; loc_addr = a; loc_wdata = d;
    @(negedge clk);
    loc_we = 0;
  endtask

  task automatic lr(input logic [AW-1:0] a, output logic [7:0] d);
    @(negedge clk);
    loc_addr = a;
    #1 d = loc_rdata;
  endtask

  task automatic t_reset;
    chk("R1 miso", {15'b0, miso}, 16'h0);
    chk("R1 attn", {15'b0, attn}, 16'h0);
    chk("R1 msg_ready", {15'b0, msg_ready}, 16'h0);
    sel;
    xfer(8'h00, r);
    chk("R1 tx byte after reset", {8'h0, r}, 16'h0000);
    desel;
  endtask

  task automatic t_local;
    logic [7:0] q;
    lw(5'd3, 8'h5A);
    lr(5'd3, q);
    chk("R10 local readback", {8'h0, q}, 16'h005A);
  endtask

  task automatic t_write;
    logic [7:0] q;
    int c0 = rdy_cnt;
    sel;
    xfer(8'h00, r); chk("R3 idle status", {8'h0, r}, 16'h0000);
    xfer(8'h03, r); chk("R6 header slot repeats", {8'h0, r}, 16'h0000);
    xfer(8'h11, r); xfer(8'h22, r); xfer(8'h33, r);
    xfer(8'hFF, r); chk("R5 stream idx0", {8'h0, r}, 16'h0011);
    xfer(8'hFF, r); chk("R5 stream idx1", {8'h0, r}, 16'h0022);
    xfer(8'hFF, r); chk("R5 stream idx2", {8'h0, r}, 16'h0033);
    xfer(8'hFF, r); chk("R6 repeat last", {8'h0, r}, 16'h0033);
    desel;
    chk("R4 one strobe", 16'(rdy_cnt - c0), 16'd1);
    chk("R4 msg_len", msg_len, 16'd3);
    lr(5'd0, q); chk("R2 stored byte0", {8'h0, q}, 16'h0011);
    lr(5'd2, q); chk("R4 stored byte2", {8'h0, q}, 16'h0033);
  endtask

  task automatic t_busy;
    loc_busy = 1;
    sel; xfer(8'h00, r); desel;
    loc_busy = 0;
    chk("R3 busy status", {8'h0, r}, 16'h0001);
  endtask

  task automatic t_post;
    lw(5'd0, 8'hC3);
    lw(5'd1, 8'h3C);
    @(negedge clk); loc_post = 1; loc_post_len = 6'd2;
    @(negedge clk); loc_post = 0;
    chk("R8 attn raised", {15'b0, attn}, 16'h1);
    sel;
    xfer(8'h00, r); chk("R3 data coming", {8'h0, r}, 16'h00A5);
    xfer(8'h00, r); chk("R6 status repeats", {8'h0, r}, 16'h00A5);
    xfer(8'h00, r); chk("R5 posted idx0", {8'h0, r}, 16'h00C3);
    xfer(8'h00, r); chk("R5 posted idx1", {8'h0, r}, 16'h003C);
    xfer(8'h00, r); chk("R6 posted repeat", {8'h0, r}, 16'h003C);
    desel;
    chk("R8 attn cleared", {15'b0, attn}, 16'h0);
  endtask

  task automatic t_overflow;
    logic [7:0] q;
    sel;
    xfer(8'h00, r);
    xfer(8'h22, r);
    for (int i = 0; i < 34; i++) xfer(8'(8'h40 + i), r);
    xfer(8'h00, r); chk("R7 stream idx0", {8'h0, r}, 16'h0040);
    xfer(8'h00, r); chk("R7 stream idx1", {8'h0, r}, 16'h0041);
    desel;
    chk("R7 msg_len", msg_len, 16'h0022);
    lr(5'd31, q); chk("R7 last stored", {8'h0, q}, 16'h005F);
    lr(5'd0, q);  chk("R7 no wrap", {8'h0, q}, 16'h0040);
    sel; xfer(8'h00, r); desel;
    chk("R7 overflow status", {8'h0, r}, 16'h0080);
    sel; xfer(8'h00, r); desel;
    chk("R3 overflow cleared", {8'h0, r}, 16'h0000);
  endtask

  task automatic t_abort;
    logic [7:0] q;
    int c0 = rdy_cnt;
    sel;
    xfer(8'h00, r); xfer(8'h05, r); xfer(8'hAA, r); xfer(8'hBB, r);
    desel;
    chk("R9 no strobe on abort", 16'(rdy_cnt - c0), 16'd0);
    sel;
    xfer(8'h00, r); xfer(8'h01, r); xfer(8'h77, r);
    xfer(8'h00, r); chk("R9 fresh header stream", {8'h0, r}, 16'h0077);
    desel;
    chk("R9 strobe after restart", 16'(rdy_cnt - c0), 16'd1);
    chk("R9 msg_len", msg_len, 16'd1);
    lr(5'd0, q); chk("R9 stored", {8'h0, q}, 16'h0077);
  endtask

  initial begin
    wclk(4);
    rst_n = 1;
    wclk(4);
    t_reset;
    t_local;
    t_write;
    t_busy;
    t_post;
    t_overflow;
    t_abort;
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule